// File: doc/BRIEF.md
# Nibble RAM Address Register Unit

This unit holds the data-memory pointer of a 4-bit processor core: a 12-bit address register split into a low nibble (bits 3:0), a middle nibble (bits 7:4) and a high part (bits 11:8). Next to it sit a 4-bit spare register that trades places with the middle nibble, and a one-shot address mask. The core's decoder hands the unit one operation per cycle, with the opcode's low four bits already separated out. The unit walks the pointer up and down, swaps fields with the accumulator or the spare register, and compares the low nibble with an immediate value. It also applies the post-access flip of the middle nibble that load and exchange instructions perform. It drives the effective RAM address and a skip flag that the sequencer uses to discard the next instruction.

The one-shot mask is a small state machine with two states. `MASK_IDLE` means the address passes through unmasked. `MASK_ARMED` means the stored mask bits are cleared out of the address. The transition `arm` (operation `OP_ARM_MASK`) enters or re-enters `MASK_ARMED` and loads a new mask. The transition `consume` (operation `OP_MEM_REF`) leaves `MASK_ARMED` for `MASK_IDLE` at the end of the single memory access it shaped. No other operation changes this state.

Operations take effect at the rising clock edge. The effective address and the accumulator return value are combinational from the registers, so a memory access sees the address in the same cycle that the access is requested.

Top module: `ram_addr_unit`

## Requirements
- R1: After reset the address register, spare register, mask and skip flag are all zero, so `ram_addr` reads 0, `skip` reads 0 and a first swap of the middle nibble with the spare register loads 0 into it.
- R2: `ram_addr` always equals the address register ANDed with the inverse of the active mask. The active mask is the stored mask in `MASK_ARMED` and zero in `MASK_IDLE`.
- R3: Code 8 (arm) with `op_valid` loads `wide_in` as the mask. The first following code 5 (memory reference) still uses that mask for its own access, and the mask reads as zero from the next cycle on.
- R4: Code 5 (memory reference) asserts `mem_access` in its cycle and, at the edge, XORs bits 6:4 of the address register with the inverse of `op_lo[2:0]`. Bits 11:7 and 3:0 are left unchanged.
- R5: Code 1 adds one to bits 3:0 modulo 16, and `skip` becomes 1 exactly when the result is 0.
- R6: Code 2 subtracts one from bits 3:0 modulo 16, and `skip` becomes 1 exactly when the result is 15.
- R7: Code 3 presents the current bits 3:0 on `acc_out` with `acc_load` high in that cycle, and loads `acc_in` into bits 3:0 at the edge.
- R8: Code 4 swaps bits 7:4 of the address register with the spare register. The old spare value appears in bits 7:4 of `ram_addr`.
- R9: Code 6 sets `skip` to 1 exactly when bits 3:0 equal `op_lo[3:0]`, and leaves the address unchanged.
- R10: Code 7 loads `wide_in` into the whole address register.
- R11: Each operation changes only its own field. Any valid operation that does not test for a skip (codes 0, 3, 4, 5, 7, 8) clears `skip`. With `op_valid` low, all state holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code (0 none, 1 inc, 2 dec, 3 swap low/acc, 4 swap mid/spare, 5 memory reference, 6 compare, 7 load pointer, 8 arm mask) |
| op_lo | input | 4 | Decoded low opcode bits |
| acc_in | input | 4 | Accumulator value for the low-nibble swap |
| wide_in | input | 12 | Pointer value for load, mask value for arm |
| ram_addr | output | 12 | Effective RAM address |
| mem_access | output | 1 | A memory reference uses `ram_addr` this cycle |
| acc_out | output | 4 | Old low nibble returned to the accumulator |
| acc_load | output | 1 | `acc_out` is to be written into the accumulator |
| skip | output | 1 | Skip the next instruction |

## Verification
Long random mixes of all nine codes, with random pointer, mask and immediate values, catch a field that leaks into a neighbour or a skip flag that is not cleared. Each result is compared with a bench model after every edge. Directed runs step the low nibble across both wrap points (15 to 0 on increment, 0 to 15 on decrement), which tells a correct modulo-16 skip from an off-by-one or a carry into the middle nibble. A mask is armed and then followed by two memory references, which separates a mask that drops after exactly one access from one that drops too early or stays. A memory reference on a pointer with bit 7 set shows whether the flip is limited to bits 6:4.

// File: rtl/ram_addr_pkg.sv
package ram_addr_pkg;

    typedef enum logic [3:0] {
        OP_NOP          = 4'd0,
        OP_INC_BL       = 4'd1,
        OP_DEC_BL       = 4'd2,
        OP_SWAP_BL_ACC  = 4'd3,
        OP_SWAP_BM_X    = 4'd4,
        OP_MEM_REF      = 4'd5,
        OP_CMP_BL       = 4'd6,
        OP_LOAD_B       = 4'd7,
        OP_ARM_MASK     = 4'd8
    } rau_op_e;

    typedef enum logic {
        MASK_IDLE  = 1'b0,
        MASK_ARMED = 1'b1
    } mask_state_e;

endpackage

// File: rtl/rau_low_step.sv
module rau_low_step
    import ram_addr_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  rau_op_e           op,
    input  logic              op_valid,
    input  logic [NIB_W-1:0]  low_cur,
    input  logic [NIB_W-1:0]  imm,
    input  logic [NIB_W-1:0]  acc_in,
    output logic [NIB_W-1:0]  low_next,
    output logic              skip_next
);
    localparam logic [NIB_W-1:0] ALL_ONES = '1;

    logic [NIB_W-1:0] up_val;
    logic [NIB_W-1:0] dn_val;

    always_comb begin
        up_val    = low_cur + 1'b1;
        dn_val    = low_cur - 1'b1;
        low_next  = low_cur;
        skip_next = 1'b0;
        if (op_valid) begin
            unique case (op)
                OP_INC_BL: begin
                    low_next  = up_val;
                    skip_next = (up_val == '0);
                end
                OP_DEC_BL: begin
                    low_next  = dn_val;
                    skip_next = (dn_val == ALL_ONES);
                end
                OP_CMP_BL:      skip_next = (low_cur == imm);
                OP_SWAP_BL_ACC: low_next  = acc_in;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rau_mask_fsm.sv
module rau_mask_fsm
    import ram_addr_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              consume,
    input  logic [ADDR_W-1:0] mask_in,
    output logic [ADDR_W-1:0] mask_out
);
    mask_state_e       state_q, state_d;
    logic [ADDR_W-1:0] mask_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MASK_IDLE:  if (arm) state_d = MASK_ARMED;
            MASK_ARMED: if (consume) state_d = MASK_IDLE;
                        else if (arm) state_d = MASK_ARMED;
            default:    state_d = MASK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MASK_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (arm) mask_q <= mask_in;
        end
    end

    always_comb begin
        unique case (state_q)
            MASK_ARMED: mask_out = mask_q;
            default:    mask_out = '0;
        endcase
    end
endmodule

// File: rtl/ram_addr_unit.sv
module ram_addr_unit
    import ram_addr_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int NIB_W    = 4,
    parameter int FLIP_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op,
    input  logic [NIB_W-1:0]  op_lo,
    input  logic [NIB_W-1:0]  acc_in,
    input  logic [ADDR_W-1:0] wide_in,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              mem_access,
    output logic [NIB_W-1:0]  acc_out,
    output logic              acc_load,
    output logic              skip
);
    localparam int MID_LO = NIB_W;
    localparam int MID_HI = 2*NIB_W - 1;

    rau_op_e           op_e;
    logic [ADDR_W-1:0] b_q, b_d;
    logic [NIB_W-1:0]  x_q, x_d;
    logic              skip_q;
    logic [NIB_W-1:0]  low_next;
    logic              skip_next;
    logic [ADDR_W-1:0] mask_act;
    logic              arm, consume;
    logic [FLIP_W-1:0] flip;

    assign op_e    = rau_op_e'(op);
    assign arm     = op_valid && (op_e == OP_ARM_MASK);
    assign consume = op_valid && (op_e == OP_MEM_REF);
    assign flip    = ~op_lo[FLIP_W-1:0];

    rau_low_step #(.NIB_W(NIB_W)) u_low (
        .op       (op_e),
        .op_valid (op_valid),
        .low_cur  (b_q[NIB_W-1:0]),
        .imm      (op_lo),
        .acc_in   (acc_in),
        .low_next (low_next),
        .skip_next(skip_next)
    );

    rau_mask_fsm #(.ADDR_W(ADDR_W)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .consume (consume),
        .mask_in (wide_in),
        .mask_out(mask_act)
    );

    always_comb begin
        b_d = b_q;
        x_d = x_q;
        b_d[NIB_W-1:0] = low_next;
        if (op_valid) begin
            unique case (op_e)
                OP_SWAP_BM_X: begin
                    b_d[MID_HI:MID_LO] = x_q;
                    x_d                = b_q[MID_HI:MID_LO];
                end
                OP_MEM_REF:
                    b_d[MID_LO+FLIP_W-1:MID_LO] = b_q[MID_LO+FLIP_W-1:MID_LO] ^ flip;
                OP_LOAD_B: b_d = wide_in;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q    <= '0;
            x_q    <= '0;
            skip_q <= 1'b0;
        end else begin
            b_q <= b_d;
            x_q <= x_d;
            if (op_valid) skip_q <= skip_next;
        end
    end

    always_comb begin
        ram_addr   = b_q & ~mask_act;
        mem_access = consume;
        acc_load   = op_valid && (op_e == OP_SWAP_BL_ACC);
        acc_out    = b_q[NIB_W-1:0];
        skip       = skip_q;
    end
endmodule

// File: rtl/ram_addr_unit_chk.sv
module ram_addr_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        op_valid,
    input logic [3:0]  op,
    input logic [3:0]  op_lo,
    input logic [11:0] b_q,
    input logic [3:0]  x_q,
    input logic [11:0] mask_act,
    input logic        skip
);
    // R3: one memory reference consumes the mask
    a_r3_mask_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd5) |=> (mask_act == 12'd0));

    // R5: increment wraps and skips on zero
    a_r5_inc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd1) |=>
        (b_q[3:0] == 4'($past(b_q[3:0]) + 4'd1)) && (skip == (b_q[3:0] == 4'd0)));

    // R6: decrement wraps and skips on fifteen
    a_r6_dec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd2) |=>
        (b_q[3:0] == 4'($past(b_q[3:0]) - 4'd1)) && (skip == (b_q[3:0] == 4'hF)));

    // R8: middle nibble and spare register trade places
    a_r8_swap_mid: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd4) |=>
        (b_q[7:4] == $past(x_q)) && (x_q == $past(b_q[7:4])));

    // R4: memory reference leaves bits outside 6:4 alone
    a_r4_flip_field: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == 4'd5) |=>
        (b_q[11:7] == $past(b_q[11:7])) && (b_q[3:0] == $past(b_q[3:0])));

    // R11: idle cycles hold all state
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(b_q) && $stable(x_q) && $stable(skip)));

    // R11: high part only changes on pointer load
    a_r11_high_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op != 4'd7) |=> $stable(b_q[11:8]));
endmodule

bind ram_addr_unit ram_addr_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op      (op),
    .op_lo   (op_lo),
    .b_q     (b_q),
    .x_q     (x_q),
    .mask_act(mask_act),
    .skip    (skip)
);

// File: tb/tb_ram_addr_unit.sv
module tb_ram_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [3:0]  op_lo = '0;
    logic [3:0]  acc_in = '0;
    logic [11:0] wide_in = '0;
    logic [11:0] ram_addr;
    logic        mem_access;
    logic [3:0]  acc_out;
    logic        acc_load;
    logic        skip;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // bench model
    logic [11:0] m_b = '0;
    logic [3:0]  m_x = '0;
    logic [11:0] m_mask = '0;
    logic        m_skip = 1'b0;

    ram_addr_unit dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .op_lo(op_lo),
        .acc_in(acc_in), .wide_in(wide_in), .ram_addr(ram_addr),
        .mem_access(mem_access), .acc_out(acc_out), .acc_load(acc_load), .skip(skip)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
            finish_run();
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic v, logic [3:0] code);
        if (!v) return "R11";
        case (code)
            4'd1: return "R5";
            4'd2: return "R6";
            4'd3: return "R7";
            4'd4: return "R8";
            4'd5: return "R4";
            4'd6: return "R9";
            4'd7: return "R10";
            4'd8: return "R3";
            default: return "R11";
        endcase
    endfunction

    // One cycle: drive, check combinational outputs, clock, update model, check state.
    task automatic step(logic v, logic [3:0] code, logic [3:0] lo,
                        logic [3:0] acc, logic [11:0] w);
        string t;
        logic [3:0] nb;
        t = tag_of(v, code);
        @(negedge clk);
        op_valid = v; op = code; op_lo = lo; acc_in = acc; wide_in = w;
        #1;
        check("R2 ram_addr", ram_addr, m_b & ~m_mask);
        check("R4 mem_access", mem_access, v && code == 4'd5);
        check("R7 acc_load", acc_load, v && code == 4'd3);
        if (v && code == 4'd3) check("R7 acc_out", acc_out, m_b[3:0]);
        @(posedge clk);
        if (v) begin
            m_skip = 1'b0;
            case (code)
                4'd1: begin nb = m_b[3:0] + 4'd1; m_b[3:0] = nb; m_skip = (nb == 4'd0); end
                4'd2: begin nb = m_b[3:0] - 4'd1; m_b[3:0] = nb; m_skip = (nb == 4'hF); end
                4'd3: m_b[3:0] = acc;
                4'd4: begin nb = m_b[7:4]; m_b[7:4] = m_x; m_x = nb; end
                4'd5: begin m_b[6:4] = m_b[6:4] ^ ~lo[2:0]; m_mask = '0; end
                4'd6: m_skip = (m_b[3:0] == lo);
                4'd7: m_b = w;
                4'd8: m_mask = w;
                default: ;
            endcase
        end
        #1;
        check({t, " addr after"}, ram_addr, m_b & ~m_mask);
        check({t, " skip"}, skip, m_skip);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #12;
        // R1: reset state
        check("R1 ram_addr", ram_addr, 12'h000);
        check("R1 skip", skip, 1'b0);
        rst_n = 1'b1;
        // R1: spare register reset to zero, seen through swap
        step(1, 4'd7, 4'd0, 4'd0, 12'hA5C);
        step(1, 4'd4, 4'd0, 4'd0, 12'h000);
        check("R1 spare zero", ram_addr[7:4], 4'h0);
        // R5: increment across wrap
        step(1, 4'd7, 4'd0, 4'd0, 12'h3CE);
        step(1, 4'd1, 4'd0, 4'd0, 12'h000);
        check("R5 no skip at F", skip, 1'b0);
        step(1, 4'd1, 4'd0, 4'd0, 12'h000);
        check("R5 wrap to 0 keeps mid", ram_addr, 12'h3C0);
        check("R5 skip on 0", skip, 1'b1);
        // R11: idle holds skip, then NOP clears it
        step(0, 4'd1, 4'd0, 4'd0, 12'h000);
        check("R11 idle hold skip", skip, 1'b1);
        step(1, 4'd0, 4'd0, 4'd0, 12'h000);
        check("R11 nop clears skip", skip, 1'b0);
        // R6: decrement across wrap
        step(1, 4'd2, 4'd0, 4'd0, 12'h000);
        check("R6 wrap to F", ram_addr, 12'h3CF);
        check("R6 skip on F", skip, 1'b1);
        // R9: compare
        step(1, 4'd6, 4'hF, 4'd0, 12'h000);
        check("R9 equal", skip, 1'b1);
        step(1, 4'd6, 4'hE, 4'd0, 12'h000);
        check("R9 not equal", skip, 1'b0);
        // R3: mask survives one access, then drops
        step(1, 4'd7, 4'd0, 4'd0, 12'hFFF);
        step(1, 4'd8, 4'd0, 4'd0, 12'h0F0);
        check("R3 masked", ram_addr, 12'hF0F);
        step(1, 4'd5, 4'd7, 4'd0, 12'h000);
        check("R3 mask gone", ram_addr, 12'hFFF);
        // R4: bit 7 untouched, 6:4 flipped by ~lo
        step(1, 4'd5, 4'd2, 4'd0, 12'h000);
        check("R4 flip 6:4 only", ram_addr, 12'hFAF);
        // R7: swap low nibble with accumulator
        step(1, 4'd3, 4'd0, 4'h6, 12'h000);
        check("R7 low loaded", ram_addr, 12'hFA6);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 8) != 0, 4'($urandom % 9), 4'($urandom), 4'($urandom),
                 12'($urandom));
        end
        finish_run();
    end
endmodule